// File: doc/BRIEF.md
# Fractional Stream Rate Limiter

This block sits inline on a valid/ready stream and limits how often beats may pass. The limit is the fraction `rate_num / rate_den` of the clock rate. It meets that limit by holding back beats for idle cycles. It does not buffer anything. Data, byte enables, end-of-frame and the error flag go straight from the input port to the output port. The only change is that the output valid is withheld while the limiter is pacing, and the input ready is withheld at the same time.

Pacing is driven by a signed credit counter. Every clock adds the numerator to the credit. Every beat that moves subtracts the denominator. The credit is clamped above at the denominator, so an idle spell can only bank a burst of limited size.

Two pacing modes can be selected at run time:
- **Per-beat pacing** checks the credit before every beat.
- **Per-frame pacing** checks the credit only before the first beat of a frame. The rest of that frame runs at full speed, and the credit it overdraws is paid back by idle cycles after the frame ends.

Top module: `stream_rate_throttle`

## Requirements
- R1: Whenever `m_tvalid` is high, `m_tdata`, `m_tkeep`, `m_tlast` and `m_tuser` equal the matching `s_` inputs, and `m_tvalid` is high only if `s_tvalid` is high. No beat is lost or repeated.
- R2: `s_tready` is low whenever `m_tready` is low. `s_tready` is also low in any cycle the limiter is pacing.
- R3: When `rate_num` equals `rate_den`, a continuous input with `m_tready` high moves one beat on every clock.
- R4: Behaviour in per-beat pacing (`frame_mode` = 0):
  - The credit rises by `rate_num` every clock and falls by `rate_den` on every transfer.
  - A beat may pass only while the credit is zero or positive.
  - Starting from zero credit, ratio 1/3 moves 4 beats in 10 cycles, and ratio 2/3 moves 6 beats in 9 cycles.
- R5: The credit never rises above `rate_den`. With ratio 1/3, after a long idle spell from reset, 4 beats take 7 cycles.
- R6: Behaviour in per-frame pacing (`frame_mode` = 1):
  - Once the first beat of a frame has passed, no idle cycle is inserted before that frame's `tlast` beat.
  - The overdraft is repaid after the frame. Ratio 1/2 with 4-beat frames moves 8 beats in 12 cycles; ratio 3/4 with 2-beat frames moves 4 beats in 5 cycles.
- R7: In per-beat pacing, `s_tlast` has no effect on pacing. Ratio 1/2 moves 8 beats in 15 cycles whatever the frame length.
- R8: The rate inputs can change while the block runs, with no reset. The accumulated credit carries over: ratio 1/3 followed by ratio 1/1 moves the next 4 beats in 6 cycles.
- R9: If `frame_mode` drops to 0 in the middle of a frame that started under per-frame pacing, the remaining beats of that frame still pass without idles. Per-beat pacing starts with the next frame.
- R10: After reset the credit is zero and no frame is open, so `s_tready` follows `m_tready` and `m_tvalid` is low while `s_tvalid` is low.
- R11: A beat that is offered but held off by a low `m_tready` uses no credit. With ratio 1/2, three cycles of back-pressure right after reset, followed by release, let exactly 3 beats through before the first idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_num | input | RATE_W | Ratio numerator, 1..rate_den |
| rate_den | input | RATE_W | Ratio denominator |
| frame_mode | input | 1 | Pacing mode: 0 = per-beat pacing, 1 = per-frame pacing |
| s_tdata | input | DATA_W | Input data |
| s_tkeep | input | KEEP_W | Input byte enables |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| s_tlast | input | 1 | Input end of frame |
| s_tuser | input | 1 | Input bad-frame flag |
| m_tdata | output | DATA_W | Output data |
| m_tkeep | output | KEEP_W | Output byte enables |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Output sink ready |
| m_tlast | output | 1 | Output end of frame |
| m_tuser | output | 1 | Output bad-frame flag |

## Verification
The bench builds the block with `DATA_W` = 16, `KEEP_W` = 2 and `RATE_W` = 8, and keeps the default credit headroom of 6 bits. Sixteen data bits are enough to carry a row number and a beat number, so any reordering or dropped beat shows up in the data compare. The small ratios used by the tests (1/3, 2/3, 1/2, 3/4 and 1/1) produce short, hand-countable idle patterns, and they reach the upper credit clamp within twenty idle cycles. The frames the tests use are too short to reach the lower credit floor, so that clamp is covered only by its assertion-free arithmetic.

// File: rtl/rate_throttle_pkg.sv
package rate_throttle_pkg;

  // Pacing policy selected by the frame_mode pin
  typedef enum logic {
    PACE_WORD  = 1'b0,
    PACE_FRAME = 1'b1
  } pace_mode_e;

endpackage

// File: rtl/rt_credit_acc.sv
module rt_credit_acc #(
  parameter int RATE_W = 8,
  parameter int CRED_W = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [RATE_W-1:0]        num,
  input  logic [RATE_W-1:0]        den,
  input  logic                     take,
  output logic signed [CRED_W-1:0] cred_q,
  output logic                     credit_ok
);

  localparam int EXT_W = CRED_W + 2;
  localparam logic signed [EXT_W-1:0] FLOOR = {{3{1'b1}}, {(CRED_W-1){1'b0}}};

  function automatic logic signed [EXT_W-1:0] widen_rate(input logic [RATE_W-1:0] r);
    return $signed({{(EXT_W-RATE_W){1'b0}}, r});
  endfunction

  function automatic logic signed [EXT_W-1:0] widen_cred(input logic signed [CRED_W-1:0] c);
    return $signed({{2{c[CRED_W-1]}}, c});
  endfunction

  // One clock of credit arithmetic: earn num, pay den on a beat, clamp both ends
  function automatic logic signed [CRED_W-1:0] step_credit(
    input logic signed [CRED_W-1:0] c,
    input logic [RATE_W-1:0]        n,
    input logic [RATE_W-1:0]        d,
    input logic                     tk
  );
    logic signed [EXT_W-1:0] s;
    s = widen_cred(c) + widen_rate(n);
    if (tk) s = s - widen_rate(d);
    if (s > widen_rate(d))  s = widen_rate(d);
    else if (s < FLOOR)     s = FLOOR;
    return $signed(s[CRED_W-1:0]);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cred_q <= '0;
    else        cred_q <= step_credit(cred_q, num, den, take);
  end

  assign credit_ok = ~cred_q[CRED_W-1];

  // Credit never exceeds the denominator that was in force when it was computed
  assert_credit_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    widen_cred(cred_q) <= $past(widen_rate(den)));

  // An idle cycle below the cap earns exactly num
  assert_idle_gain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && (widen_cred(cred_q) + widen_rate(num) <= widen_rate(den)))
    |=> (widen_cred(cred_q) == $past(widen_cred(cred_q) + widen_rate(num))));

endmodule

// File: rtl/rt_frame_track.sv
module rt_frame_track (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer,
  input  logic last,
  input  logic frame_pace,
  output logic hold_q
);

  // hold_q: a frame opened under per-frame pacing is still running
  function automatic logic next_hold(input logic h, input logic x, input logic l, input logic fp);
    if (!x) return h;
    return !l && (fp || h);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= next_hold(hold_q, xfer, last, frame_pace);
  end

  // A held frame closes only on its tlast beat
  assert_hold_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> $past(xfer && last));

endmodule

// File: rtl/stream_rate_throttle.sv
module stream_rate_throttle
  import rate_throttle_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int KEEP_W    = (DATA_W + 7) / 8,
  parameter int RATE_W    = 8,
  parameter int CRED_HEAD = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_num,
  input  logic [RATE_W-1:0] rate_den,
  input  logic              frame_mode,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic [KEEP_W-1:0] s_tkeep,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic              s_tlast,
  input  logic              s_tuser,
  output logic [DATA_W-1:0] m_tdata,
  output logic [KEEP_W-1:0] m_tkeep,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              m_tlast,
  output logic              m_tuser
);

  localparam int CRED_W = RATE_W + CRED_HEAD;

  pace_mode_e               mode_sel;
  logic                     xfer;
  logic                     permit;
  logic                     credit_ok;
  logic                     hold_q;
  logic signed [CRED_W-1:0] cred_q;

  assign mode_sel = pace_mode_e'(frame_mode);

  rt_credit_acc #(
    .RATE_W(RATE_W),
    .CRED_W(CRED_W)
  ) acc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .num      (rate_num),
    .den      (rate_den),
    .take     (xfer),
    .cred_q   (cred_q),
    .credit_ok(credit_ok)
  );

  rt_frame_track trk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .xfer      (xfer),
    .last      (s_tlast),
    .frame_pace(mode_sel == PACE_FRAME),
    .hold_q    (hold_q)
  );

  // Open held frame runs free; otherwise a beat needs non-negative credit
  assign permit   = hold_q | credit_ok;
  assign s_tready = m_tready & permit;
  assign m_tvalid = s_tvalid & permit;
  assign xfer     = s_tvalid & s_tready;

  assign m_tdata = s_tdata;
  assign m_tkeep = s_tkeep;
  assign m_tlast = s_tlast;
  assign m_tuser = s_tuser;

  assert_out_needs_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> s_tvalid);

  assert_backpressure_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !m_tready |-> !s_tready);

  assert_frame_nostall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && s_tvalid && m_tready) |-> s_tready);

  assert_pace_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !hold_q) |-> (cred_q >= 0));

endmodule

// File: tb/stream_rate_throttle_tb_top.sv
`timescale 1ns/1ps
module stream_rate_throttle_tb_top;

  localparam int DW = 16;
  localparam int KW = 2;
  localparam int RW = 8;

  typedef struct packed {
    logic [7:0] num;
    logic [7:0] den;
    logic       frame;
    logic [3:0] flen;
    logic [4:0] nbeats;
    logic [5:0] pre_idle;
    logic       do_rst;
    logic       sw_word;
    logic [6:0] exp_cyc;
  } row_t;

  localparam int NROWS = 9;
  localparam row_t ROWS [NROWS] = '{
    '{8'd1, 8'd1, 1'b0, 4'd4, 5'd8, 6'd0,  1'b1, 1'b0, 7'd8},   // R3 full rate
    '{8'd1, 8'd3, 1'b0, 4'd4, 5'd4, 6'd0,  1'b1, 1'b0, 7'd10},  // R4 one in three
    '{8'd1, 8'd1, 1'b0, 4'd4, 5'd4, 6'd0,  1'b0, 1'b0, 7'd6},   // R8 live change, debt kept
    '{8'd2, 8'd3, 1'b0, 4'd4, 5'd6, 6'd0,  1'b1, 1'b0, 7'd9},   // R4 two in three
    '{8'd1, 8'd2, 1'b0, 4'd4, 5'd8, 6'd0,  1'b1, 1'b0, 7'd15},  // R7 tlast ignored
    '{8'd1, 8'd2, 1'b1, 4'd4, 5'd8, 6'd0,  1'b1, 1'b0, 7'd12},  // R6 frame pacing
    '{8'd3, 8'd4, 1'b1, 4'd2, 5'd4, 6'd0,  1'b1, 1'b0, 7'd5},   // R6 short frames
    '{8'd1, 8'd3, 1'b0, 4'd4, 5'd4, 6'd20, 1'b1, 1'b0, 7'd7},   // R5 credit cap
    '{8'd1, 8'd2, 1'b1, 4'd4, 5'd6, 6'd0,  1'b1, 1'b1, 7'd11}   // R9 mode drop mid-frame
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [RW-1:0] rate_num = 8'd1;
  logic [RW-1:0] rate_den = 8'd1;
  logic          frame_mode = 1'b0;
  logic [DW-1:0] s_tdata = '0;
  logic [KW-1:0] s_tkeep = '0;
  logic          s_tvalid = 1'b0;
  logic          s_tready;
  logic          s_tlast = 1'b0;
  logic          s_tuser = 1'b0;
  logic [DW-1:0] m_tdata;
  logic [KW-1:0] m_tkeep;
  logic          m_tvalid;
  logic          m_tready = 1'b1;
  logic          m_tlast;
  logic          m_tuser;

  int   total = 0;
  int   bad = 0;
  row_t v;
  int   beat;
  int   cyc;
  bit   data_ok;
  bit   ok;
  int   npass;

  always #2 clk = ~clk;

  stream_rate_throttle #(
    .DATA_W(DW),
    .KEEP_W(KW),
    .RATE_W(RW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .rate_num(rate_num), .rate_den(rate_den), .frame_mode(frame_mode),
    .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tvalid(s_tvalid), .s_tready(s_tready),
    .s_tlast(s_tlast), .s_tuser(s_tuser),
    .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tlast(m_tlast), .m_tuser(m_tuser)
  );

  task automatic chk(input bit cond, input string what, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    s_tvalid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drive(input int row, input int b, input int flen);
    s_tdata = {8'(row), 8'(b)};
    s_tkeep = KW'(b) ^ 2'b01;
    s_tlast = ((b + 1) % flen) == 0;
    s_tuser = s_tlast && (((b / 4) % 2) == 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 200000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // Table of pacing scenarios
    for (int r = 0; r < NROWS; r++) begin
      v = ROWS[r];
      if (v.do_rst) do_reset();
      else @(negedge clk);
      rate_num = v.num;
      rate_den = v.den;
      frame_mode = v.frame;
      m_tready = 1'b1;
      s_tvalid = 1'b0;
      for (int k = 0; k < int'(v.pre_idle); k++) @(negedge clk);
      beat = 0;
      cyc = 0;
      data_ok = 1'b1;
      while (beat < int'(v.nbeats) && cyc < 100) begin
        if (cyc != 0) @(negedge clk);
        if (v.sw_word && beat >= 1) frame_mode = 1'b0;
        drive(r, beat, int'(v.flen));
        s_tvalid = 1'b1;
        #1;
        if (m_tvalid && (m_tdata !== s_tdata || m_tkeep !== s_tkeep ||
                         m_tlast !== s_tlast || m_tuser !== s_tuser))
          data_ok = 1'b0;
        if (m_tvalid !== s_tready) data_ok = 1'b0;
        if (s_tvalid && s_tready) beat++;
        cyc++;
      end
      chk(cyc == int'(v.exp_cyc), $sformatf("row %0d cycle count", r), cyc, int'(v.exp_cyc));
      chk(data_ok, $sformatf("R1 row %0d passthrough", r), int'(data_ok), 1);
    end

    // R10 reset state
    do_reset();
    rate_num = 8'd1;
    rate_den = 8'd2;
    frame_mode = 1'b0;
    s_tvalid = 1'b0;
    m_tready = 1'b1;
    #1;
    chk(m_tvalid == 1'b0, "R10 m_tvalid after reset", int'(m_tvalid), 0);
    chk(s_tready == 1'b1, "R10 s_tready after reset", int'(s_tready), 1);

    // R2 and R11 back-pressure consumes no credit
    do_reset();
    rate_num = 8'd1;
    rate_den = 8'd2;
    frame_mode = 1'b0;
    drive(99, 5, 16);
    s_tvalid = 1'b1;
    m_tready = 1'b0;
    ok = 1'b1;
    for (int k = 0; k < 3; k++) begin
      if (k != 0) @(negedge clk);
      #1;
      if (s_tready !== 1'b0 || m_tvalid !== 1'b1 || m_tdata !== s_tdata) ok = 1'b0;
    end
    chk(ok, "R2 ready low under back-pressure", int'(ok), 1);
    npass = 0;
    ok = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      m_tready = 1'b1;
      #1;
      if (s_tready) npass++;
      if (k == 3 && s_tready !== 1'b0) ok = 1'b0;
    end
    chk(npass == 3, "R11 beats after release", npass, 3);
    chk(ok, "R11 idle after banked credit", int'(ok), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule